// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a cache and the memory below it and holds writes that have not yet reached memory. In word mode the cache hands it every store as a single word. In line mode it hands over each dirty line that a miss evicts. Queued entries go out to memory one at a time, oldest first, over a single shared memory port.

A read miss does not wait for the queue to empty. The block first compares the read address with every queued address. On a match, the read is answered from the newest queued data and memory is not touched. With no match, the read goes to memory at once, ahead of all queued writes. Draining starts again only after the read has been answered. In line mode the cache enqueues the victim line first and then issues the miss, so the fill is fetched before the victim is written back.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset the buffer is empty, `wr_full` is 0, `mem_req` is 0, `rd_ready` is 1 and `rd_resp_valid` is 0.
- R2: A write is taken at a clock edge when `wr_valid` is 1 and `wr_full` is 0. `wr_full` rises once DEPTH distinct addresses are queued. A write offered while `wr_full` is 1 is dropped and never reaches memory.
- R3: With no read pending, queued entries are written to memory in the order they arrived, one per edge at which `mem_req`, `mem_we` and `mem_ready` are all 1. While the port is stalled the oldest entry stays on `mem_addr`/`mem_wdata`.
- R4: A write whose address is already queued, and whose entry is not leaving that edge, overwrites that entry's data and takes no new slot. Memory then sees one write for that address, carrying the latest data.
- R5: A read request is taken when `rd_ready` is 1. Its address is compared against the queue as it stands after that edge, so a write taken at the same edge counts as older than the read.
- R6: On a queue match, `rd_resp_valid` is 1 for one cycle, two edges after the request edge. It carries the newest queued data for that address with `rd_resp_fwd` = 1, and no memory read is made.
- R7: On a miss, a memory read (`mem_req` = 1, `mem_we` = 0, `mem_addr` = read address) is presented from two edges after the request and held until `mem_ready`. It goes ahead of every queued write.
- R8: After a memory read, `rd_resp_valid` rises one edge after the edge at which `mem_rvalid` is 1. It carries `mem_rdata` with `rd_resp_fwd` = 0.
- R9: From the edge a read is taken until its response, no memory write is presented, and a request arriving while the block is idle also blocks the drain that cycle. Draining resumes after the response.
- R10: With WRITE_BACK = 1, each entry and each memory transfer is a whole line of LINE_WORDS words. A victim line enqueued together with a missing read is written to memory after that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write offered |
| wr_addr | input | ADDR_W | Write address (word or line address) |
| wr_data | input | BLK_W | Write data: one word, or one line in line mode |
| wr_full | output | 1 | Queue full; offered writes are not taken |
| rd_req | input | 1 | Read miss request |
| rd_addr | input | ADDR_W | Read address |
| rd_ready | output | 1 | Read port idle, request can be taken |
| rd_resp_valid | output | 1 | Read response, one-cycle pulse |
| rd_resp_data | output | BLK_W | Read response data |
| rd_resp_fwd | output | 1 | Response came from the queue |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | BLK_W | Memory write data |
| mem_ready | input | 1 | Memory accepts the transfer this edge |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | BLK_W | Memory read data |

## Verification
Timing is counted in clock edges. A queue hit answers two edges after the request edge. A miss shows its memory read two edges after the request. A memory response reaches `rd_resp_valid` one edge after the `mem_rvalid` edge. Each drained entry takes one edge with `mem_ready` high. The bench drives inputs and takes its samples at falling edges, and counts falling edges from each stimulus to the edge at which a result is due. A monitor records every memory transfer a quarter period before the rising edge that completes it, so the order of reads and writes on the port can be compared with the order the requirements call for.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

   typedef enum logic [1:0] {
      RD_IDLE  = 2'd0,
      RD_LOOK  = 2'd1,
      RD_ISSUE = 2'd2,
      RD_WAIT  = 2'd3
   } rd_state_e;

   function automatic bit is_pow2(input int n);
      return (n > 1) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
   parameter int AW    = 16,
   parameter int BW    = 32,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_en,
   input  logic [AW-1:0]    push_addr,
   input  logic [BW-1:0]    push_data,
   input  logic             pop_en,
   input  logic [AW-1:0]    look_addr,
   output logic [AW-1:0]    head_addr,
   output logic [BW-1:0]    head_data,
   output logic             empty,
   output logic             full,
   output logic             look_hit,
   output logic [BW-1:0]    look_data,
   output logic [DEPTH-1:0] look_vec,
   output logic [DEPTH-1:0] live_vec
);

   logic [PW-1:0]       head_q;
   logic [PW:0]         cnt_q;
   logic [PW-1:0]       tail;
   logic [DEPTH-1:0]    merge_vec;
   logic                merge;
   logic [DEPTH*AW-1:0] addr_flat;
   logic [DEPTH*BW-1:0] data_flat;
   logic [DEPTH*BW-1:0] look_part;

   assign tail  = head_q + cnt_q[PW-1:0];
   assign merge = |merge_vec;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         logic [AW-1:0] slot_addr;
         logic [BW-1:0] slot_data;
         logic [PW-1:0] off;

         assign off          = PW'(i) - head_q;
         assign live_vec[i]  = ({1'b0, off} < cnt_q);
         assign look_vec[i]  = live_vec[i] && (slot_addr == look_addr);
         assign merge_vec[i] = live_vec[i] && (slot_addr == push_addr)
                               && !(pop_en && (head_q == PW'(i)));

         assign addr_flat[i*AW +: AW] = slot_addr;
         assign data_flat[i*BW +: BW] = slot_data;
         assign look_part[i*BW +: BW] = look_vec[i] ? slot_data : '0;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_addr <= '0;
               slot_data <= '0;
            end else if (push_en) begin
               if (merge_vec[i]) begin
                  slot_data <= push_data;
               end else if (!merge && (tail == PW'(i))) begin
                  slot_addr <= push_addr;
                  slot_data <= push_data;
               end
            end
         end
      end
   endgenerate

   always_comb begin
      look_data = '0;
      for (int k = 0; k < DEPTH; k++) begin
         look_data = look_data | look_part[k*BW +: BW];
      end
   end

   assign look_hit  = |look_vec;
   assign head_addr = addr_flat[head_q*AW +: AW];
   assign head_data = data_flat[head_q*BW +: BW];
   assign empty     = (cnt_q == '0);
   assign full      = (cnt_q == (PW+1)'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         cnt_q  <= '0;
      end else begin
         head_q <= head_q + PW'(pop_en);
         cnt_q  <= cnt_q + (PW+1)'(push_en && !merge) - (PW+1)'(pop_en);
      end
   end

endmodule

// File: rtl/wbuf_rdctl.sv
module wbuf_rdctl
   import wbuf_pkg::*;
#(
   parameter int AW = 16,
   parameter int BW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_req,
   input  logic [AW-1:0] rd_addr,
   input  logic          look_hit,
   input  logic [BW-1:0] look_data,
   input  logic          mem_ready,
   input  logic          mem_rvalid,
   input  logic [BW-1:0] mem_rdata,
   output logic          rd_ready,
   output logic          rd_busy,
   output logic          rd_issue,
   output logic [AW-1:0] look_addr,
   output logic          rsp_valid,
   output logic [BW-1:0] rsp_data,
   output logic          rsp_fwd
);

   rd_state_e     st_q;
   logic [AW-1:0] addr_q;

   assign rd_ready  = (st_q == RD_IDLE);
   assign rd_busy   = (st_q != RD_IDLE);
   assign rd_issue  = (st_q == RD_ISSUE);
   assign look_addr = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= RD_IDLE;
         addr_q    <= '0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_fwd   <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (st_q)
            RD_IDLE: begin
               if (rd_req) begin
                  addr_q <= rd_addr;
                  st_q   <= RD_LOOK;
               end
            end
            RD_LOOK: begin
               if (look_hit) begin
                  rsp_valid <= 1'b1;
                  rsp_data  <= look_data;
                  rsp_fwd   <= 1'b1;
                  st_q      <= RD_IDLE;
               end else begin
                  st_q <= RD_ISSUE;
               end
            end
            RD_ISSUE: begin
               if (mem_ready) st_q <= RD_WAIT;
            end
            RD_WAIT: begin
               if (mem_rvalid) begin
                  rsp_valid <= 1'b1;
                  rsp_data  <= mem_rdata;
                  rsp_fwd   <= 1'b0;
                  st_q      <= RD_IDLE;
               end
            end
            default: st_q <= RD_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/wbuf_mem_arb.sv
module wbuf_mem_arb #(
   parameter int AW = 16,
   parameter int BW = 32
) (
   input  logic          rd_issue,
   input  logic          rd_busy,
   input  logic          rd_req,
   input  logic          q_empty,
   input  logic [AW-1:0] rd_addr,
   input  logic [AW-1:0] head_addr,
   input  logic [BW-1:0] head_data,
   input  logic          mem_ready,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [BW-1:0] mem_wdata,
   output logic          pop
);

   logic drain_ok;

   // a read in flight or arriving owns the port; writes only fill idle cycles
   assign drain_ok  = !rd_busy && !rd_req && !q_empty;
   assign mem_req   = rd_issue || drain_ok;
   assign mem_we    = !rd_issue && drain_ok;
   assign mem_addr  = rd_issue ? rd_addr : head_addr;
   assign mem_wdata = mem_we ? head_data : '0;
   assign pop       = mem_we && mem_ready;

endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass
   import wbuf_pkg::*;
#(
   parameter int  ADDR_W     = 16,
   parameter int  WORD_W     = 32,
   parameter int  LINE_WORDS = 4,
   parameter bit  WRITE_BACK = 1'b0,
   parameter int  DEPTH      = 4,
   localparam int BLK_W      = WORD_W * (WRITE_BACK ? LINE_WORDS : 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BLK_W-1:0]  wr_data,
   output logic              wr_full,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_ready,
   output logic              rd_resp_valid,
   output logic [BLK_W-1:0]  rd_resp_data,
   output logic              rd_resp_fwd,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BLK_W-1:0]  mem_wdata,
   input  logic              mem_ready,
   input  logic              mem_rvalid,
   input  logic [BLK_W-1:0]  mem_rdata
);

   generate
      if (!is_pow2(DEPTH)) begin : g_bad_depth
         $error("wbuf_bypass: DEPTH must be a power of two, at least 2");
      end
      if (ADDR_W < 1 || WORD_W < 1) begin : g_bad_width
         $error("wbuf_bypass: ADDR_W and WORD_W must be positive");
      end
      if (WRITE_BACK) begin : g_line_mode
         if (LINE_WORDS < 2) begin : g_bad_line
            $error("wbuf_bypass: line mode needs LINE_WORDS of at least 2");
         end
      end
   endgenerate

   logic              push_en;
   logic              pop;
   logic              q_empty;
   logic              q_full;
   logic [ADDR_W-1:0] head_addr;
   logic [BLK_W-1:0]  head_data;
   logic [ADDR_W-1:0] look_addr;
   logic              look_hit;
   logic [BLK_W-1:0]  look_data;
   logic [DEPTH-1:0]  look_vec;
   logic [DEPTH-1:0]  live_vec;
   logic              rd_busy;
   logic              rd_issue;

   assign wr_full = q_full;
   assign push_en = wr_valid && !q_full;

   wbuf_store #(.AW(ADDR_W), .BW(BLK_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_en   (push_en),
      .push_addr (wr_addr),
      .push_data (wr_data),
      .pop_en    (pop),
      .look_addr (look_addr),
      .head_addr (head_addr),
      .head_data (head_data),
      .empty     (q_empty),
      .full      (q_full),
      .look_hit  (look_hit),
      .look_data (look_data),
      .look_vec  (look_vec),
      .live_vec  (live_vec)
   );

   wbuf_rdctl #(.AW(ADDR_W), .BW(BLK_W)) u_rdctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_req     (rd_req),
      .rd_addr    (rd_addr),
      .look_hit   (look_hit),
      .look_data  (look_data),
      .mem_ready  (mem_ready),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .rd_ready   (rd_ready),
      .rd_busy    (rd_busy),
      .rd_issue   (rd_issue),
      .look_addr  (look_addr),
      .rsp_valid  (rd_resp_valid),
      .rsp_data   (rd_resp_data),
      .rsp_fwd    (rd_resp_fwd)
   );

   wbuf_mem_arb #(.AW(ADDR_W), .BW(BLK_W)) u_arb (
      .rd_issue  (rd_issue),
      .rd_busy   (rd_busy),
      .rd_req    (rd_req),
      .q_empty   (q_empty),
      .rd_addr   (look_addr),
      .head_addr (head_addr),
      .head_data (head_data),
      .mem_ready (mem_ready),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .pop       (pop)
   );

endmodule

// File: rtl/wbuf_bypass_chk.sv
module wbuf_bypass_chk #(
   parameter int AW    = 16,
   parameter int DEPTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_full,
   input logic             rd_ready,
   input logic             rd_busy,
   input logic             rd_resp_valid,
   input logic             mem_req,
   input logic             mem_we,
   input logic             mem_ready,
   input logic [AW-1:0]    mem_addr,
   input logic [DEPTH-1:0] look_vec,
   input logic [DEPTH-1:0] live_vec
);

   p_full_all_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_full |-> (&live_vec));

   p_drain_has_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (|live_vec));

   p_unique_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(look_vec) <= 1);

   p_resp_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_resp_valid |-> rd_ready);

   p_resp_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_resp_valid |=> !rd_resp_valid);

   p_read_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> rd_busy);

   p_read_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && !mem_ready) |=> (mem_req && !mem_we && $stable(mem_addr)));

   p_no_drain_in_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_busy |-> !(mem_req && mem_we));

endmodule

bind wbuf_bypass wbuf_bypass_chk #(.AW(ADDR_W), .DEPTH(DEPTH)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_full       (wr_full),
   .rd_ready      (rd_ready),
   .rd_busy       (rd_busy),
   .rd_resp_valid (rd_resp_valid),
   .mem_req       (mem_req),
   .mem_we        (mem_we),
   .mem_ready     (mem_ready),
   .mem_addr      (mem_addr),
   .look_vec      (look_vec),
   .live_vec      (live_vec)
);

// File: tb/wbuf_bypass_tb.sv
module wbuf_bypass_tb;

   localparam int AW  = 16;
   localparam int BW  = 32;
   localparam int LBW = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   // word-mode instance
   logic          wr_valid = 0, rd_req = 0, mem_ready = 0, mem_rvalid = 0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [BW-1:0] wr_data = '0, mem_rdata = '0;
   logic          wr_full, rd_ready, rd_resp_valid, rd_resp_fwd, mem_req, mem_we;
   logic [BW-1:0] rd_resp_data, mem_wdata;
   logic [AW-1:0] mem_addr;

   // line-mode instance
   logic           l_wr_valid = 0, l_rd_req = 0, l_mem_ready = 0, l_mem_rvalid = 0;
   logic [AW-1:0]  l_wr_addr = '0, l_rd_addr = '0;
   logic [LBW-1:0] l_wr_data = '0, l_mem_rdata = '0;
   logic           l_wr_full, l_rd_ready, l_rd_resp_valid, l_rd_resp_fwd, l_mem_req, l_mem_we;
   logic [LBW-1:0] l_rd_resp_data, l_mem_wdata;
   logic [AW-1:0]  l_mem_addr;

   wbuf_bypass #(.ADDR_W(AW), .WORD_W(BW), .LINE_WORDS(4), .WRITE_BACK(1'b0), .DEPTH(4)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_full(wr_full),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
      .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data), .rd_resp_fwd(rd_resp_fwd),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   wbuf_bypass #(.ADDR_W(AW), .WORD_W(BW), .LINE_WORDS(4), .WRITE_BACK(1'b1), .DEPTH(4)) u_dut_line (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(l_wr_valid), .wr_addr(l_wr_addr), .wr_data(l_wr_data), .wr_full(l_wr_full),
      .rd_req(l_rd_req), .rd_addr(l_rd_addr), .rd_ready(l_rd_ready),
      .rd_resp_valid(l_rd_resp_valid), .rd_resp_data(l_rd_resp_data), .rd_resp_fwd(l_rd_resp_fwd),
      .mem_req(l_mem_req), .mem_we(l_mem_we), .mem_addr(l_mem_addr), .mem_wdata(l_mem_wdata),
      .mem_ready(l_mem_ready), .mem_rvalid(l_mem_rvalid), .mem_rdata(l_mem_rdata)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   // transfer logs, sampled 5 ns before the completing rising edge
   logic          lg_we   [32];
   logic [AW-1:0] lg_addr [32];
   logic [BW-1:0] lg_data [32];
   int            lg_n = 0;
   logic           ll_we   [8];
   logic [AW-1:0]  ll_addr [8];
   logic [LBW-1:0] ll_data [8];
   int             ll_n = 0;

   always begin
      @(negedge clk);
      #5;
      if (rst_n && mem_req && mem_ready && lg_n < 32) begin
         lg_we[lg_n] = mem_we; lg_addr[lg_n] = mem_addr; lg_data[lg_n] = mem_wdata;
         lg_n = lg_n + 1;
      end
      if (rst_n && l_mem_req && l_mem_ready && ll_n < 8) begin
         ll_we[ll_n] = l_mem_we; ll_addr[ll_n] = l_mem_addr; ll_data[ll_n] = l_mem_wdata;
         ll_n = ll_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [LBW-1:0] act,
                      input logic [LBW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic push(input logic [AW-1:0] a, input logic [BW-1:0] d);
      wr_valid = 1; wr_addr = a; wr_data = d;
      tick();
      wr_valid = 0;
   endtask

   task automatic drain(input int n);
      mem_ready = 1;
      repeat (n) tick();
      mem_ready = 0;
   endtask

   task automatic t_reset();
      chk(wr_full == 0,       "R1 wr_full",       wr_full, 0);
      chk(mem_req == 0,       "R1 mem_req",       mem_req, 0);
      chk(rd_ready == 1,      "R1 rd_ready",      rd_ready, 1);
      chk(rd_resp_valid == 0, "R1 rd_resp_valid", rd_resp_valid, 0);
   endtask

   task automatic t_fifo();
      int base = lg_n;
      push(16'h10, 32'hA0); push(16'h11, 32'hA1); push(16'h12, 32'hA2);
      chk(mem_req && mem_we && mem_addr == 16'h10 && mem_wdata == 32'hA0,
          "R3 head held while stalled", mem_addr, 16'h10);
      drain(4);
      chk(lg_n - base == 3, "R3 drain count", lg_n - base, 3);
      for (int i = 0; i < 3; i++)
         chk(lg_we[base+i] && lg_addr[base+i] == AW'(16 + i) && lg_data[base+i] == BW'(160 + i),
             "R3 drain order", lg_addr[base+i], 16 + i);
   endtask

   task automatic t_full();
      int base = lg_n;
      for (int i = 0; i < 4; i++) push(AW'(32 + i), BW'(32'hB0 + i));
      chk(wr_full == 1, "R2 full after four", wr_full, 1);
      wr_valid = 1; wr_addr = 16'h24; wr_data = 32'hEE;
      tick();
      wr_valid = 0;
      chk(wr_full == 1, "R2 still full", wr_full, 1);
      drain(6);
      chk(lg_n - base == 4, "R2 dropped write not drained", lg_n - base, 4);
      chk(lg_addr[base+3] == 16'h23, "R2 last drained", lg_addr[base+3], 16'h23);
      chk(wr_full == 0, "R2 full clears", wr_full, 0);
   endtask

   task automatic t_merge();
      int base = lg_n;
      push(16'h30, 32'h1); push(16'h31, 32'h2); push(16'h30, 32'h3);
      push(16'h32, 32'h4); push(16'h33, 32'h5);
      chk(wr_full == 1, "R4 merge took no slot", wr_full, 1);
      drain(6);
      chk(lg_n - base == 4, "R4 one write per address", lg_n - base, 4);
      chk(lg_addr[base] == 16'h30 && lg_data[base] == 32'h3, "R4 latest data", lg_data[base], 32'h3);
      chk(lg_addr[base+1] == 16'h31, "R4 order kept", lg_addr[base+1], 16'h31);
   endtask

   task automatic t_hit();
      push(16'h40, 32'h11); push(16'h40, 32'h22);
      rd_req = 1; rd_addr = 16'h40;
      tick();
      rd_req = 0;
      chk(mem_req == 0, "R9 no drain during lookup", mem_req, 0);
      tick();
      chk(rd_resp_valid && rd_resp_fwd && rd_resp_data == 32'h22,
          "R6 hit returns newest", rd_resp_data, 32'h22);
      wr_valid = 1; wr_addr = 16'h42; wr_data = 32'h44;
      rd_req = 1; rd_addr = 16'h42;
      tick();
      wr_valid = 0; rd_req = 0;
      tick();
      chk(rd_resp_valid && rd_resp_fwd && rd_resp_data == 32'h44,
          "R5 same-edge write seen", rd_resp_data, 32'h44);
      drain(4);
   endtask

   task automatic t_bypass();
      int base;
      push(16'h50, 32'h5); push(16'h51, 32'h6);
      base = lg_n;
      rd_req = 1; rd_addr = 16'h77;
      tick();
      rd_req = 0;
      chk(mem_req == 0, "R9 port quiet in lookup", mem_req, 0);
      tick();
      chk(mem_req && !mem_we && mem_addr == 16'h77, "R7 read issued", mem_addr, 16'h77);
      tick();
      chk(mem_req && !mem_we && mem_addr == 16'h77, "R7 read held", mem_addr, 16'h77);
      mem_ready = 1;
      tick();
      chk(mem_req == 0, "R9 writes wait for response", mem_req, 0);
      mem_rvalid = 1; mem_rdata = 32'hBEEF;
      tick();
      mem_rvalid = 0;
      chk(rd_resp_valid && !rd_resp_fwd && rd_resp_data == 32'hBEEF,
          "R8 memory response", rd_resp_data, 32'hBEEF);
      repeat (3) tick();
      mem_ready = 0;
      chk(lg_n - base == 3, "R7 transfer count", lg_n - base, 3);
      chk(!lg_we[base] && lg_addr[base] == 16'h77, "R7 read before writes", lg_addr[base], 16'h77);
      chk(lg_we[base+1] && lg_addr[base+1] == 16'h50 && lg_we[base+2] && lg_addr[base+2] == 16'h51,
          "R9 drain resumes in order", lg_addr[base+1], 16'h50);
   endtask

   task automatic t_line();
      int base = ll_n;
      logic [LBW-1:0] victim = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
      logic [LBW-1:0] fill   = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
      l_mem_ready = 1;
      l_wr_valid = 1; l_wr_addr = 16'h5; l_wr_data = victim;
      l_rd_req = 1; l_rd_addr = 16'h9;
      tick();
      l_wr_valid = 0; l_rd_req = 0;
      chk(l_mem_req == 0, "R10 victim waits in lookup", l_mem_req, 0);
      tick();
      chk(l_mem_req && !l_mem_we && l_mem_addr == 16'h9, "R10 fill read first", l_mem_addr, 16'h9);
      tick();
      l_mem_rvalid = 1; l_mem_rdata = fill;
      tick();
      l_mem_rvalid = 0;
      chk(l_rd_resp_valid && l_rd_resp_data == fill, "R10 line response", l_rd_resp_data, fill);
      repeat (2) tick();
      l_mem_ready = 0;
      chk(ll_n - base == 2, "R10 transfer count", ll_n - base, 2);
      chk(ll_we[base+1] && ll_addr[base+1] == 16'h5 && ll_data[base+1] == victim,
          "R10 whole victim line written after", ll_data[base+1], victim);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1;
      tick();
      t_reset();
      t_fifo();
      t_full();
      t_merge();
      t_hit();
      t_bypass();
      t_line();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule